// File: doc/BRIEF.md
# Button-Driven Up/Down Code Stepper

The block turns two push-button inputs, one for stepping up and one for stepping down, into a 4-bit code. The code moves by one position for every click. Each raw button passes through a two-flop synchroniser. A divider on the fast system clock produces a one-cycle sampling tick. It runs at 80 Hz with the default 50 MHz clock, and this sets the rate at which a small binary-encoded Moore state machine reads the buttons.

For each press, however long, the state machine raises a step-enable output for exactly one sampling period. During that same period it raises a direction output, but only when the press came from the up button. A wrapping modulo-16 counter applies the step at the tick that ends the pulse. A second press needs the button to be released first.

An optional repeat mode can be enabled. While it is on and a single button stays held, a further step is issued every 80 sampling ticks, which is one second. Holding a button therefore walks through all sixteen codes in sixteen seconds.

Top module: `code_stepper`

## Requirements
- R1: `step_en_o` changes only at a sampling tick. Every pulse lasts exactly one sampling period, which is `TICK_DIV` system clocks.
- R2: `step_up_o` is high only while `step_en_o` is high. It is 1 for a pulse caused by the up button and 0 for a pulse caused by the down button.
- R3: With repeat mode off, one press yields exactly one pulse, however long the button is held. Two pulses are never adjacent.
- R4: `code_o` rises by 1 after an up pulse and falls by 1 after a down pulse. The change happens on the clock after the tick that ends the pulse. At all other times `code_o` holds its value.
- R5: The code wraps. Stepping up from 15 gives 0, and stepping down from 0 gives 15.
- R6: The sampling tick occurs once every `TICK_DIV` system clocks. The default is 625000, which gives 80 Hz from 50 MHz.
- R7: If both buttons are seen pressed while idle, no pulse is issued. The machine then waits until both buttons are released, even if one of them stays held alone.
- R8: With `repeat_en_i` high, a single button that stays held produces one pulse at the first sample and then a further pulse every `REPEAT_TICKS` ticks (default 80) until it is released.
- R9: A synchronous active-high `rst` sets `code_o` to 0 and clears `step_en_o` and `step_up_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_up_i | input | 1 | Raw up button, high when pressed |
| btn_dn_i | input | 1 | Raw down button, high when pressed |
| repeat_en_i | input | 1 | Enables hold-to-repeat stepping |
| code_o | output | CODE_W | Current code |
| step_en_o | output | 1 | Step pulse, one sampling period long |
| step_up_o | output | 1 | Direction of the current step, 1 for up |

## Verification
The checker assumes that the buttons are asynchronous levels, and that the only paths from the buttons to the outputs pass through the two-flop synchroniser and the sampling tick. It also assumes that `repeat_en_i` stays steady around the samples that matter, so every property is stated relative to the tick and never to the button edges. The stimulus only changes inputs on falling clock edges. It holds or releases each button for whole multiples of the sampling period, and it keeps at least several idle periods between presses, so every press is seen cleanly and a release is always observed before the next press.

// File: rtl/code_stepper_pkg.sv
package code_stepper_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_STEP_UP = 2'b01,
    ST_STEP_DN = 2'b10,
    ST_HELD    = 2'b11
  } press_state_t;
endpackage

// File: rtl/sample_tick_gen.sv
module sample_tick_gen #(
  parameter int TICK_DIV = 625000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (cnt_q == LAST);
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] sync_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= raw_i[i];
        stab_q <= meta_q;
      end
    end
    assign sync_o[i] = stab_q;
  end
endmodule

// File: rtl/press_fsm.sv
module press_fsm
  import code_stepper_pkg::*;
#(
  parameter int REPEAT_TICKS = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic up_i,
  input  logic dn_i,
  input  logic repeat_en_i,
  output logic step_en_o,
  output logic step_up_o
);
  localparam int RW = (REPEAT_TICKS > 2) ? $clog2(REPEAT_TICKS) : 1;
  localparam logic [RW-1:0] RPT_LAST = RW'(REPEAT_TICKS - 2);

  press_state_t state_q, state_d;
  logic          dir_q, dir_d;
  logic          rpt_ok_q, rpt_ok_d;
  logic [RW-1:0] rpt_q, rpt_d;
  logic          held_same;

  assign held_same = rpt_ok_q && (dir_q ? (up_i && !dn_i) : (dn_i && !up_i));

  always_comb begin
    state_d  = state_q;
    dir_d    = dir_q;
    rpt_ok_d = rpt_ok_q;
    rpt_d    = rpt_q;
    case (state_q)
      ST_IDLE: begin
        rpt_d = '0;
        if (up_i && dn_i) begin
          state_d  = ST_HELD;
          rpt_ok_d = 1'b0;
        end else if (up_i) begin
          state_d = ST_STEP_UP;
          dir_d   = 1'b1;
        end else if (dn_i) begin
          state_d = ST_STEP_DN;
          dir_d   = 1'b0;
        end
      end
      ST_STEP_UP, ST_STEP_DN: begin
        state_d  = ST_HELD;
        rpt_ok_d = 1'b1;
        rpt_d    = '0;
      end
      default: begin
        if (!up_i && !dn_i) begin
          state_d = ST_IDLE;
          rpt_d   = '0;
        end else if (repeat_en_i && held_same) begin
          if (rpt_q >= RPT_LAST) begin
            state_d = dir_q ? ST_STEP_UP : ST_STEP_DN;
            rpt_d   = '0;
          end else begin
            rpt_d = rpt_q + 1'b1;
          end
        end else begin
          rpt_d = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      dir_q     <= 1'b0;
      rpt_ok_q  <= 1'b0;
      rpt_q     <= '0;
      step_en_o <= 1'b0;
      step_up_o <= 1'b0;
    end else if (tick_i) begin
      state_q   <= state_d;
      dir_q     <= dir_d;
      rpt_ok_q  <= rpt_ok_d;
      rpt_q     <= rpt_d;
      step_en_o <= (state_d == ST_STEP_UP) || (state_d == ST_STEP_DN);
      step_up_o <= (state_d == ST_STEP_UP);
    end
  end
endmodule

// File: rtl/wrap_counter.sv
module wrap_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic         up_i,
  output logic [W-1:0] val_o
);
  always_ff @(posedge clk) begin
    if (rst)       val_o <= '0;
    else if (en_i) val_o <= up_i ? val_o + 1'b1 : val_o - 1'b1;
  end
endmodule

// File: rtl/code_stepper.sv
module code_stepper #(
  parameter int TICK_DIV     = 625000,
  parameter int REPEAT_TICKS = 80,
  parameter int CODE_W       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              btn_up_i,
  input  logic              btn_dn_i,
  input  logic              repeat_en_i,
  output logic [CODE_W-1:0] code_o,
  output logic              step_en_o,
  output logic              step_up_o
);
  localparam int NBTN = 2;

  logic            tick_w;
  logic [NBTN-1:0] btn_s;

  sample_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick_w)
  );

  btn_sync #(.N(NBTN)) u_sync (
    .clk(clk), .rst(rst), .raw_i({btn_dn_i, btn_up_i}), .sync_o(btn_s)
  );

  press_fsm #(.REPEAT_TICKS(REPEAT_TICKS)) u_fsm (
    .clk(clk), .rst(rst), .tick_i(tick_w),
    .up_i(btn_s[0]), .dn_i(btn_s[1]), .repeat_en_i(repeat_en_i),
    .step_en_o(step_en_o), .step_up_o(step_up_o)
  );

  wrap_counter #(.W(CODE_W)) u_cnt (
    .clk(clk), .rst(rst), .en_i(tick_w && step_en_o),
    .up_i(step_up_o), .val_o(code_o)
  );
endmodule

// File: rtl/code_stepper_checker.sv
module code_stepper_checker #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic [CODE_W-1:0] code_o,
  input logic              step_en_o,
  input logic              step_up_o
);
  assert_en_on_tick_R1: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(step_en_o));

  assert_dir_in_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    step_up_o |-> step_en_o);

  assert_single_period_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && step_en_o) |=> !step_en_o);

  assert_hold_code_R4: assert property (@(posedge clk) disable iff (rst)
    !(tick && step_en_o) |=> $stable(code_o));

  assert_up_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && step_en_o && step_up_o) |=> code_o == CODE_W'($past(code_o) + 1'b1));

  assert_dn_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && step_en_o && !step_up_o) |=> code_o == CODE_W'($past(code_o) - 1'b1));

  assert_reset_R9: assert property (@(posedge clk)
    rst |=> (code_o == '0 && !step_en_o && !step_up_o));
endmodule

bind code_stepper code_stepper_checker #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick_w), .code_o(code_o),
  .step_en_o(step_en_o), .step_up_o(step_up_o)
);

// File: tb/code_stepper_bench.sv
module code_stepper_bench;
  localparam int TD = 4;
  localparam int RT = 5;
  localparam int NV = 8;
  // fields: up, dn, hold ticks[5:0], expected code[3:0], expected new pulses[3:0]
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 1'b0, 6'd3,  4'd1,  4'd1},
    {1'b1, 1'b0, 6'd10, 4'd2,  4'd1},
    {1'b0, 1'b1, 6'd2,  4'd1,  4'd1},
    {1'b0, 1'b1, 6'd3,  4'd0,  4'd1},
    {1'b0, 1'b1, 6'd3,  4'd15, 4'd1},
    {1'b1, 1'b0, 6'd3,  4'd0,  4'd1},
    {1'b1, 1'b1, 6'd4,  4'd0,  4'd0},
    {1'b1, 1'b0, 6'd3,  4'd1,  4'd1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up = 1'b0, dn = 1'b0, rep = 1'b0;
  logic [3:0] code;
  logic en, dir;

  int checks = 0, errors = 0;
  int pulses = 0, width = 0;
  logic exp_dir = 1'b0;
  logic prev_en = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  code_stepper #(.TICK_DIV(TD), .REPEAT_TICKS(RT), .CODE_W(4)) u_code_stepper (
    .clk(clk), .rst(rst), .btn_up_i(up), .btn_dn_i(dn), .repeat_en_i(rep),
    .code_o(code), .step_en_o(en), .step_up_o(dir)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pulse monitor: counts pulses, checks width (R1, R6) and direction (R2)
  always @(negedge clk) begin
    if (rst) begin
      prev_en <= 1'b0;
      width   <= 0;
    end else begin
      if (en && !prev_en) begin
        pulses++;
        chk(dir == exp_dir, "R2 direction", int'(dir), int'(exp_dir));
      end
      if (en) width <= width + 1;
      if (!en && prev_en) begin
        chk(width == TD, "R1/R6 pulse width", width, TD);
        width <= 0;
      end
      prev_en <= en;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input logic u, input logic d, input int ticks);
    exp_dir = u;
    up = u; dn = d;
    wait_cyc(ticks * TD);
    up = 1'b0; dn = 1'b0;
    wait_cyc(4 * TD);
  endtask

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
    chk(code == 4'd0 && !en && !dir, "R9 reset state", int'(code), 0);

    for (int i = 0; i < NV; i++) begin
      int p0;
      p0 = pulses;
      press(VEC[i][15], VEC[i][14], int'(VEC[i][13:8]));
      chk(code == VEC[i][7:4], "R4/R5 code after press", int'(code), int'(VEC[i][7:4]));
      chk(pulses - p0 == int'(VEC[i][3:0]), "R3/R7 pulse count", pulses - p0, int'(VEC[i][3:0]));
    end

    // R7: both pressed, then down released while up stays held: still no pulse
    begin
      int p0;
      p0 = pulses;
      up = 1'b1; dn = 1'b1;
      wait_cyc(3 * TD);
      dn = 1'b0;
      wait_cyc(5 * TD);
      up = 1'b0;
      wait_cyc(4 * TD);
      chk(pulses == p0, "R7 lone button after double press", pulses - p0, 0);
      chk(code == 4'd1, "R7 code unchanged", int'(code), 1);
    end

    // R3: long hold with repeat off gives only one step
    begin
      int p0;
      p0 = pulses;
      press(1'b1, 1'b0, 20);
      chk(pulses - p0 == 1, "R3 long hold single pulse", pulses - p0, 1);
      chk(code == 4'd2, "R3 code after long hold", int'(code), 2);
    end

    // R8: repeat mode, up held 12 ticks -> pulses at 1st sample, +RT, +2RT
    rep = 1'b1;
    begin
      int p0;
      p0 = pulses;
      press(1'b1, 1'b0, 12);
      chk(pulses - p0 == 3, "R8 repeat up pulses", pulses - p0, 3);
      chk(code == 4'd5, "R8 repeat up code", int'(code), 5);
      p0 = pulses;
      press(1'b0, 1'b1, 7);
      chk(pulses - p0 == 2, "R8 repeat down pulses", pulses - p0, 2);
      chk(code == 4'd3, "R8 repeat down code", int'(code), 3);
    end
    rep = 1'b0;

    // R9: reset in the middle of operation
    rst = 1'b1;
    wait_cyc(2);
    chk(code == 4'd0 && !en, "R9 mid-run reset", int'(code), 0);
    rst = 1'b0;
    wait_cyc(2 * TD);
    chk(code == 4'd0 && !en, "R9 idle after reset", int'(code), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_cyc(20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule